// File: doc/BRIEF.md
# Bus Arbiter with Locked Read-Modify-Write Hold

This block decides who drives a shared bus: the on-chip processor or one of several external masters. The processor owns the bus by default. An external master raises a request line. The arbiter answers with a one-hot grant. The master confirms it has taken the bus by raising its acknowledge, and it releases the bus by dropping that acknowledge. A lock input from the processor marks an indivisible read-modify-write sequence. No grant is issued while the lock is active, and requests that arrive in that time are held and served as soon as the lock drops.

The arbiter also shapes the address strobe and chip select for processor cycles. A configuration bit, the split-lock mode, chooses between two behaviours. With the bit clear, both strobes are held asserted across the idle gap between the read half and the write half. With the bit set, both strobes drop in that gap and return for the write half. A second configuration bit, the clear mask, lets a pending-interrupt input drive the bus-clear output. All pins are plain control signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rmw_bus_arbiter`

## Requirements
- R1: Both configuration bits (split-lock mode and clear mask) are 0 after reset. A cycle with `cfg_we`=1 loads `cfg_split_d` and `cfg_mask_d`, and the new values govern the outputs computed from the next clock edge onward.
- R2: While reset is asserted, `ext_gnt`, `bus_as`, `bus_cs` and `bus_clr` are all 0.
- R3: While no external request is pending, `ext_gnt` stays 0 and the processor keeps the bus. In that case `bus_as` equals `cpu_cyc` as sampled at the previous edge, and `bus_cs` equals `bus_as` ANDed with the previously sampled `cpu_sel`.
- R4: A grant is offered when the processor owns the bus, `ext_req` is nonzero, and both `cpu_cyc` and `cpu_lock` are 0 at a rising edge. The grant goes to the lowest-numbered requesting master: bit i of `ext_gnt` is set, one cycle after that edge. `ext_gnt` is always one-hot or zero.
- R5: Once the granted master's `ext_ack` has been sampled high, the grant is held until an edge samples that acknowledge low, and it drops after that edge. If the request is withdrawn before any acknowledge, the grant is withdrawn at the next edge.
- R6: While `cpu_lock` is 1, no new grant is issued. This includes the gap between the read half and the write half, where `cpu_cyc` is 0.
- R7: A request that is held pending during a lock is granted one cycle after the first edge at which both `cpu_lock` and `cpu_cyc` are sampled 0.
- R8: With split-lock mode 0, `bus_as` stays 1 through a locked sequence. This includes gap cycles where `cpu_lock`=1 and `cpu_cyc`=0.
- R9: With split-lock mode 1, `bus_as` and `bus_cs` are 0 for gap cycles of a locked sequence and return to 1 for the write half.
- R10: `bus_clr` equals the clear mask ANDed with `irq_pend`, both sampled at the previous edge. While the mask is 0, `irq_pend` has no effect on `bus_clr`.
- R11: While an external master holds a grant, `bus_as` and `bus_cs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the configuration bits |
| cfg_split_d | input | 1 | New split-lock mode value |
| cfg_mask_d | input | 1 | New clear-mask value |
| cpu_cyc | input | 1 | Processor bus cycle (read or write half) in progress |
| cpu_lock | input | 1 | Processor locked read-modify-write active |
| cpu_sel | input | 1 | Processor cycle targets a selected region |
| irq_pend | input | 1 | Pending-interrupt indication |
| ext_req | input | NM | Bus request, one per external master |
| ext_ack | input | NM | Grant acknowledge, one per external master |
| ext_gnt | output | NM | One-hot bus grant |
| bus_as | output | 1 | Address strobe for processor cycles |
| bus_cs | output | 1 | Chip select for processor cycles |
| bus_clr | output | 1 | Bus-clear request |

## Verification
Every output is registered, so each result is due exactly one rising edge after the inputs that cause it are sampled. A configuration write takes one extra edge, because the loaded bits only affect outputs computed from the following edge. The bench changes inputs 1 ns after an edge and compares all outputs 1 ns after the next edge against a bench-side model stepped once per edge. The directed lock sequences check the gap cycle and the first cycle after the lock is released at exactly those offsets.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_CPU  = 2'd0,
    OFFERED  = 2'd1,
    EXT_HELD = 2'd2
  } own_state_t;
endpackage

// File: rtl/arb_cfg.sv
module arb_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_split_d,
  input  logic cfg_mask_d,
  output logic split_q,
  output logic mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= 1'b0;
      mask_q  <= 1'b0;
    end else if (cfg_we) begin
      split_q <= cfg_split_d;
      mask_q  <= cfg_mask_d;
    end
  end

  // R1: without a write the bits keep their values
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(split_q) && $stable(mask_q)));
endmodule

// File: rtl/arb_grant.sv
module arb_grant
  import arb_pkg::*;
#(
  parameter int NM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_cyc,
  input  logic          cpu_lock,
  input  logic [NM-1:0] ext_req,
  input  logic [NM-1:0] ext_ack,
  output logic [NM-1:0] ext_gnt,
  output logic          cpu_owns
);
  localparam int OW = (NM > 1) ? $clog2(NM) : 1;

  own_state_t    st_q;
  logic [OW-1:0] own_q;
  logic [OW-1:0] pick;
  logic          may_offer;

  // lowest-numbered requester wins
  always_comb begin
    pick = '0;
    for (int i = NM - 1; i >= 0; i--) begin
      if (ext_req[i]) pick = OW'(i);
    end
  end

  assign may_offer = (|ext_req) && !cpu_lock && !cpu_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OWN_CPU;
      own_q <= '0;
    end else begin
      unique case (st_q)
        OWN_CPU: if (may_offer) begin
          st_q  <= OFFERED;
          own_q <= pick;
        end
        OFFERED: begin
          if (ext_ack[own_q])      st_q <= EXT_HELD;
          else if (!ext_req[own_q]) st_q <= OWN_CPU;
        end
        EXT_HELD: if (!ext_ack[own_q]) st_q <= OWN_CPU;
        default: st_q <= OWN_CPU;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NM; g++) begin : g_gnt
      assign ext_gnt[g] = (st_q != OWN_CPU) && (own_q == OW'(g));
    end
  endgenerate

  assign cpu_owns = (st_q == OWN_CPU);

  p_gnt_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_gnt));
  p_no_gnt_in_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_owns && cpu_lock) |=> (ext_gnt == '0));
  p_hold_until_ack_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == EXT_HELD) && ext_ack[own_q]) |=> $stable(ext_gnt));
endmodule

// File: rtl/arb_strobe.sv
module arb_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_owns,
  input  logic cpu_cyc,
  input  logic cpu_lock,
  input  logic cpu_sel,
  input  logic irq_pend,
  input  logic split_q,
  input  logic mask_q,
  output logic bus_as,
  output logic bus_cs,
  output logic bus_clr
);
  logic as_d;

  // unsplit mode bridges the read/write gap while the lock is held
  assign as_d = cpu_owns && (cpu_cyc || (!split_q && cpu_lock));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_as  <= 1'b0;
      bus_cs  <= 1'b0;
      bus_clr <= 1'b0;
    end else begin
      bus_as  <= as_d;
      bus_cs  <= as_d && cpu_sel;
      bus_clr <= mask_q && irq_pend;
    end
  end

  p_split_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (split_q && !cpu_cyc) |=> (!bus_as && !bus_cs));
  p_bridge_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_owns && !split_q && cpu_lock) |=> bus_as);
  p_clr_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q |=> !bus_clr);
endmodule

// File: rtl/rmw_bus_arbiter.sv
module rmw_bus_arbiter #(
  parameter int NM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_split_d,
  input  logic          cfg_mask_d,
  input  logic          cpu_cyc,
  input  logic          cpu_lock,
  input  logic          cpu_sel,
  input  logic          irq_pend,
  input  logic [NM-1:0] ext_req,
  input  logic [NM-1:0] ext_ack,
  output logic [NM-1:0] ext_gnt,
  output logic          bus_as,
  output logic          bus_cs,
  output logic          bus_clr
);
  logic split_q, mask_q, cpu_owns;

  arb_cfg u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_split_d, .cfg_mask_d,
    .split_q, .mask_q
  );

  arb_grant #(.NM(NM)) u_grant (
    .clk, .rst_n, .cpu_cyc, .cpu_lock, .ext_req, .ext_ack,
    .ext_gnt, .cpu_owns
  );

  arb_strobe u_strobe (
    .clk, .rst_n, .cpu_owns, .cpu_cyc, .cpu_lock, .cpu_sel, .irq_pend,
    .split_q, .mask_q, .bus_as, .bus_cs, .bus_clr
  );

  p_strobe_off_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_gnt) |-> (!bus_as && !bus_cs));
  p_reset_quiet_r2: assert property (@(posedge clk)
    !rst_n |-> (ext_gnt == '0 && !bus_as && !bus_cs && !bus_clr));
endmodule

// File: tb/rmw_bus_arbiter_test.sv
module rmw_bus_arbiter_test;
  localparam int  NM = 3;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_split_d = 0, cfg_mask_d = 0;
  logic cpu_cyc = 0, cpu_lock = 0, cpu_sel = 0, irq_pend = 0;
  logic [NM-1:0] ext_req = '0, ext_ack = '0;
  logic [NM-1:0] ext_gnt;
  logic bus_as, bus_cs, bus_clr;

  int checks = 0, errors = 0;

  // bench model state
  int   m_st = 0, m_own = 0;
  logic m_split = 0, m_mask = 0, m_as = 0, m_cs = 0, m_clr = 0;

  rmw_bus_arbiter #(.NM(NM)) uut (.*);

  always #(TCLK/2) clk = ~clk;

  function automatic int lowest(input logic [NM-1:0] r);
    for (int i = NM - 1; i >= 0; i--) if (r[i]) lowest = i;
    if (r == '0) lowest = 0;
  endfunction

  function automatic logic [NM-1:0] exp_gnt();
    return (m_st == 0) ? '0 : (NM'(1) << m_own);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one edge: advance the model from the sampled inputs, then compare
  task automatic step();
    logic as_n;
    @(posedge clk);
    as_n  = (m_st == 0) && (cpu_cyc || (!m_split && cpu_lock));
    m_as  = as_n;
    m_cs  = as_n && cpu_sel;
    m_clr = m_mask && irq_pend;
    case (m_st)
      0: if ((|ext_req) && !cpu_lock && !cpu_cyc) begin m_st = 1; m_own = lowest(ext_req); end
      1: if (ext_ack[m_own]) m_st = 2; else if (!ext_req[m_own]) m_st = 0;
      default: if (!ext_ack[m_own]) m_st = 0;
    endcase
    if (cfg_we) begin m_split = cfg_split_d; m_mask = cfg_mask_d; end
    #1;
    chk("R4 gnt", int'(ext_gnt), int'(exp_gnt()));
    chk("R8 as", int'(bus_as), int'(m_as));
    chk("R3 cs", int'(bus_cs), int'(m_cs));
    chk("R10 clr", int'(bus_clr), int'(m_clr));
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(TCLK * 3 + 1ns);
    // R2: quiet while in reset
    chk("R2 gnt", int'(ext_gnt), 0);
    chk("R2 as", int'(bus_as), 0);
    chk("R2 clr", int'(bus_clr), 0);
    rst_n = 1'b1;

    // R3: processor default owner
    cpu_cyc = 1; cpu_sel = 1; step();
    chk("R3 as follows cyc", int'(bus_as), 1);
    chk("R3 no gnt", int'(ext_gnt), 0);
    cpu_cyc = 0; step();

    // R1 / R10: mask reset value ignores irq, then load it
    irq_pend = 1; step();
    chk("R1 mask resets 0", int'(bus_clr), 0);
    cfg_we = 1; cfg_mask_d = 1; step();
    cfg_we = 0; step();
    chk("R10 clr with mask", int'(bus_clr), 1);
    irq_pend = 0; step();
    chk("R10 clr follows irq", int'(bus_clr), 0);

    // R6/R7/R8: unsplit locked sequence with a request pending
    cpu_cyc = 1; cpu_lock = 1; ext_req = 3'b110; step();
    cpu_cyc = 0; step();
    chk("R8 as bridged gap", int'(bus_as), 1);
    chk("R6 no gnt in gap", int'(ext_gnt), 0);
    cpu_cyc = 1; step();
    chk("R6 no gnt write half", int'(ext_gnt), 0);
    cpu_cyc = 0; cpu_lock = 0; step();
    chk("R7 gnt after release", int'(ext_gnt), 3'b010);
    chk("R11 strobe off", int'(bus_as), 0);
    // R5: ack handshake, grant held until ack falls
    ext_ack = 3'b010; step();
    ext_req = 3'b000; step(); step();
    chk("R5 held while ack", int'(ext_gnt), 3'b010);
    ext_ack = 3'b000; step();
    chk("R5 drop after ack low", int'(ext_gnt), 0);

    // R5: request withdrawn before ack
    ext_req = 3'b001; step();
    chk("R4 lowest wins", int'(ext_gnt), 3'b001);
    ext_req = 3'b000; step();
    chk("R5 withdraw", int'(ext_gnt), 0);

    // R9: split mode drops strobes in the gap
    cfg_we = 1; cfg_split_d = 1; cfg_mask_d = 0; step();
    cfg_we = 0; cpu_cyc = 1; cpu_lock = 1; step();
    chk("R9 read half", int'(bus_cs), 1);
    cpu_cyc = 0; step();
    chk("R9 gap as", int'(bus_as), 0);
    chk("R9 gap cs", int'(bus_cs), 0);
    cpu_cyc = 1; step();
    chk("R9 write half", int'(bus_as), 1);
    cpu_cyc = 0; cpu_lock = 0; step();

    // constrained random mix, checked against the model
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 50) == 0) begin
        cfg_we = 1; cfg_split_d = 1'($urandom); cfg_mask_d = 1'($urandom);
      end else cfg_we = 0;
      cpu_cyc  = (($urandom % 3) == 0);
      cpu_lock = (($urandom % 4) == 0);
      cpu_sel  = 1'($urandom);
      irq_pend = 1'($urandom);
      ext_req  = (($urandom % 3) == 0) ? NM'($urandom) : '0;
      ext_ack  = (($urandom % 2) == 0) ? exp_gnt() : NM'($urandom);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule